// File: doc/BRIEF.md
# Vector Upper-Half State Tracker

This block follows what the upper halves of a wide vector register file hold while a stream mixes legacy 128-bit instructions with VEX-encoded 128-bit and 256-bit instructions. Each cycle the decoder presents one instruction class, a destination register index and a flag that marks a zeroing idiom. The tracker keeps a three-valued upper state and a dirty bit for each architectural register. The cycle after an instruction that costs a state-transition penalty, it raises a one-cycle pulse with a 2-bit code that names the kind of penalty.

A static generation select picks between two transition tables. The older table charges a one-time save when a legacy instruction meets dirty uppers. It then parks in a preserved state and charges a one-time restore when VEX code resumes. The newer table has no preserved state. A legacy instruction in the dirty state stays there and is charged again each time. In the newer table the tracker also raises a blend/dependency flag when that instruction's destination has a dirty upper half. Zeroing idioms get no exemption from this flag. The generation select may only change while reset is held.

Top module: `vup_tracker`

## Requirements
- R1: While the synchronous, active-high reset `rst` is sampled high, the tracker goes to state CLEAN (code 0). The dirty map becomes all zeros, `pen_code` becomes 0 (none) and `blend_dep` becomes low.
- R2: Class codes are 0 legacy-128, 1 VEX-128, 2 VEX-256 and 3 zero-upper, and any of 4 to 7 counts as other. The state codes are CLEAN 0, DIRTY 1 and PRESERVED 2. A VEX-256 instruction in CLEAN moves the state to DIRTY with no penalty, in either generation. VEX instructions in DIRTY keep DIRTY with no penalty.
- R3: A VEX-256 instruction sets bit `ins_dst` of `dirty_map` on the next edge. A VEX-128 instruction clears that bit. Legacy instructions leave the map unchanged.
- R4: With `gen_sel`=0 (older table), a legacy instruction in DIRTY gives `pen_code`=2 (save) and moves to PRESERVED. Further legacy instructions in PRESERVED give code 0 and keep PRESERVED.
- R5: With `gen_sel`=0, a VEX-128 or VEX-256 instruction in PRESERVED gives `pen_code`=3 (restore) and moves to DIRTY.
- R6: With `gen_sel`=1 (newer table), every legacy instruction in DIRTY gives `pen_code`=1 (blend) and keeps DIRTY. PRESERVED is never entered.
- R7: With `gen_sel`=1, `blend_dep` is high in the cycle after a legacy instruction in DIRTY whose destination's dirty bit is set. It is low after any other instruction, and it is always low with `gen_sel`=0.
- R8: `ins_zero_idiom` has no effect on `blend_dep`, `pen_code`, the state or the map.
- R9: A zero-upper instruction in any state gives CLEAN, clears the whole dirty map and gives code 0.
- R10: An "other" class instruction leaves the state and the map unchanged and gives code 0. A legacy or VEX-128 instruction in CLEAN gives code 0 and keeps CLEAN.
- R11: The outputs describe only the instruction of the previous cycle. `pen_pulse` is high exactly when `pen_code` is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gen_sel | input | 1 | Transition table select: 0 older one-time, 1 newer per-instruction |
| ins_class | input | 3 | Instruction class code |
| ins_dst | input | 4 | Destination vector register index |
| ins_zero_idiom | input | 1 | Instruction is a zeroing idiom |
| upper_state | output | 2 | Current upper state code |
| pen_pulse | output | 1 | Penalty raised for the previous instruction |
| pen_code | output | 2 | Penalty type: 0 none, 1 blend, 2 save, 3 restore |
| blend_dep | output | 1 | Destination needs an upper blend and carries a false dependency |
| dirty_map | output | 16 | Per-register dirty upper bits |

## Verification
Directed sequences walk each table through its transitions. The older one runs VEX-256, legacy, legacy, VEX-128 and then zero-upper, which shows a one-time save apart from a repeated one and catches a missing restore. The newer one issues back-to-back legacy instructions to the same dirty destination, then to a clean destination, then to a destination just cleared by VEX-128. This separates the state-driven blend penalty from the per-register dependency flag. Zeroing idioms are mixed in to show that they still raise the flag. Long seeded random streams in each generation, with out-of-range class codes included, then test every state and class pair against an independent model.

// File: rtl/vup_pkg.sv
package vup_pkg;
  typedef enum logic [2:0] {
    CL_LEG128 = 3'd0,
    CL_VEX128 = 3'd1,
    CL_VEX256 = 3'd2,
    CL_ZUPPER = 3'd3,
    CL_OTHER  = 3'd4
  } ucls_e;

  typedef enum logic [1:0] {
    ST_CLEAN = 2'd0,
    ST_DIRTY = 2'd1,
    ST_PRESV = 2'd2
  } ust_e;

  typedef enum logic [1:0] {
    PN_NONE    = 2'd0,
    PN_BLEND   = 2'd1,
    PN_SAVE    = 2'd2,
    PN_RESTORE = 2'd3
  } pen_e;

  typedef struct packed {
    ust_e nxt;
    pen_e pen;
  } xfer_t;

  // Transition for one instruction; newer=1 selects the self-loop table.
  function automatic xfer_t xfer(input logic newer, input ust_e cur, input logic [2:0] cls);
    xfer_t r;
    r.nxt = cur;
    r.pen = PN_NONE;
    case (cls)
      CL_ZUPPER: r.nxt = ST_CLEAN;
      CL_VEX256: begin
        if (cur == ST_CLEAN) r.nxt = ST_DIRTY;
        else if (cur == ST_PRESV) begin
          r.nxt = ST_DIRTY;
          if (!newer) r.pen = PN_RESTORE;
        end
      end
      CL_VEX128: begin
        if (cur == ST_PRESV) begin
          r.nxt = ST_DIRTY;
          if (!newer) r.pen = PN_RESTORE;
        end
      end
      CL_LEG128: begin
        if (cur == ST_DIRTY) begin
          r.nxt = newer ? ST_DIRTY : ST_PRESV;
          r.pen = newer ? PN_BLEND : PN_SAVE;
        end else if (cur == ST_PRESV && newer) begin
          r.nxt = ST_DIRTY;
          r.pen = PN_BLEND;
        end
      end
      default: ;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/vup_next.sv
module vup_next
  import vup_pkg::*;
(
  input  logic       gen_sel,
  input  logic [1:0] cur_state,
  input  logic [2:0] cls,
  output logic [1:0] nxt_state,
  output logic [1:0] pen,
  output logic       ev_blend
);
  xfer_t r;

  always_comb begin
    r         = xfer(gen_sel, ust_e'(cur_state), cls);
    nxt_state = r.nxt;
    pen       = r.pen;
    ev_blend  = gen_sel && (cls == CL_LEG128) && (cur_state == ST_DIRTY);
  end

  // R6
  newer_no_presv_chk: assert final (!(gen_sel && nxt_state == ST_PRESV));
endmodule

// File: rtl/vup_regmask.sv
module vup_regmask
  import vup_pkg::*;
#(
  parameter int NREG = 16,
  localparam int IDXW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [2:0]      cls,
  input  logic [IDXW-1:0] dst,
  output logic [NREG-1:0] map,
  output logic            dst_dirty
);
  logic wr_set, wr_clr, wipe;

  assign wr_set    = (cls == CL_VEX256);
  assign wr_clr    = (cls == CL_VEX128);
  assign wipe      = (cls == CL_ZUPPER);
  assign dst_dirty = map[dst];

  for (genvar i = 0; i < NREG; i++) begin : g_bit
    logic hit;
    assign hit = (dst == IDXW'(i));
    always_ff @(posedge clk) begin
      if (rst)                 map[i] <= 1'b0;
      else if (wipe)           map[i] <= 1'b0;
      else if (wr_set && hit)  map[i] <= 1'b1;
      else if (wr_clr && hit)  map[i] <= 1'b0;
    end
  end

  // R3
  map_set_chk: assert property (@(posedge clk) disable iff (rst)
    wr_set |=> map[$past(dst)]);
  // R3
  map_clr_chk: assert property (@(posedge clk) disable iff (rst)
    wr_clr |=> !map[$past(dst)]);
  // R3
  map_leg_chk: assert property (@(posedge clk) disable iff (rst)
    (cls == CL_LEG128) |=> $stable(map));
endmodule

// File: rtl/vup_tracker.sv
module vup_tracker
  import vup_pkg::*;
#(
  parameter int NREG = 16,
  localparam int IDXW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            gen_sel,
  input  logic [2:0]      ins_class,
  input  logic [IDXW-1:0] ins_dst,
  input  logic            ins_zero_idiom,
  output logic [1:0]      upper_state,
  output logic            pen_pulse,
  output logic [1:0]      pen_code,
  output logic            blend_dep,
  output logic [NREG-1:0] dirty_map
);
  logic [1:0] state_q, state_d, pen_d, pen_q;
  logic       ev_blend, dst_dirty, dep_d, dep_q;

  vup_next u_next (
    .gen_sel   (gen_sel),
    .cur_state (state_q),
    .cls       (ins_class),
    .nxt_state (state_d),
    .pen       (pen_d),
    .ev_blend  (ev_blend)
  );

  vup_regmask #(.NREG(NREG)) u_mask (
    .clk       (clk),
    .rst       (rst),
    .cls       (ins_class),
    .dst       (ins_dst),
    .map       (dirty_map),
    .dst_dirty (dst_dirty)
  );

  // Zeroing idioms are deliberately not consulted: the blend still needs the old value.
  assign dep_d = ev_blend && dst_dirty;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_CLEAN;
      pen_q   <= PN_NONE;
      dep_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      pen_q   <= pen_d;
      dep_q   <= dep_d;
    end
  end

  assign upper_state = state_q;
  assign pen_code    = pen_q;
  assign pen_pulse   = (pen_q != PN_NONE);
  assign blend_dep   = dep_q;

  // R4
  leg_save_chk: assert property (@(posedge clk) disable iff (rst)
    (!gen_sel && upper_state == ST_DIRTY && ins_class == CL_LEG128)
      |=> (pen_code == PN_SAVE && upper_state == ST_PRESV));
  // R4
  presv_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!gen_sel && upper_state == ST_PRESV && ins_class == CL_LEG128)
      |=> (!pen_pulse && upper_state == ST_PRESV));
  // R5
  restore_chk: assert property (@(posedge clk) disable iff (rst)
    (!gen_sel && upper_state == ST_PRESV &&
     (ins_class == CL_VEX128 || ins_class == CL_VEX256))
      |=> (pen_code == PN_RESTORE && upper_state == ST_DIRTY));
  // R6
  blend_loop_chk: assert property (@(posedge clk) disable iff (rst)
    (gen_sel && upper_state == ST_DIRTY && ins_class == CL_LEG128)
      |=> (pen_code == PN_BLEND && upper_state == ST_DIRTY));
  // R7
  dep_older_off_chk: assert property (@(posedge clk) disable iff (rst)
    !gen_sel |=> !blend_dep);
  // R8
  idiom_dep_chk: assert property (@(posedge clk) disable iff (rst)
    (gen_sel && ins_zero_idiom && upper_state == ST_DIRTY &&
     ins_class == CL_LEG128 && dirty_map[ins_dst]) |=> blend_dep);
  // R9
  zup_clean_chk: assert property (@(posedge clk) disable iff (rst)
    (ins_class == CL_ZUPPER)
      |=> (upper_state == ST_CLEAN && dirty_map == '0 && !pen_pulse));
  // R10
  other_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ins_class >= 3'd4)
      |=> ($stable(upper_state) && $stable(dirty_map) && !pen_pulse));
  // R11
  pulse_code_chk: assert property (@(posedge clk) disable iff (rst)
    pen_pulse == (pen_code != 2'd0));
endmodule

// File: tb/vup_tracker_bench.sv
`timescale 1ns/1ps
module vup_tracker_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        gen_sel = 1'b0;
  logic [2:0]  ins_class = 3'd4;
  logic [3:0]  ins_dst = '0;
  logic        ins_zero_idiom = 1'b0;
  logic [1:0]  upper_state;
  logic        pen_pulse;
  logic [1:0]  pen_code;
  logic        blend_dep;
  logic [15:0] dirty_map;

  int checks = 0;
  int errors = 0;

  logic [1:0]  m_st;
  logic [15:0] m_map;

  always #4 clk = ~clk;

  vup_tracker u_vup_tracker (
    .clk(clk), .rst(rst), .gen_sel(gen_sel), .ins_class(ins_class),
    .ins_dst(ins_dst), .ins_zero_idiom(ins_zero_idiom),
    .upper_state(upper_state), .pen_pulse(pen_pulse), .pen_code(pen_code),
    .blend_dep(blend_dep), .dirty_map(dirty_map)
  );

  // Expected {next state, penalty} restated from the requirements.
  function automatic logic [3:0] model_xfer(input logic nw, input logic [1:0] st, input logic [2:0] c);
    if (c == 3'd3) return {2'd0, 2'd0};
    if (c >= 3'd4) return {st, 2'd0};
    if (c == 3'd0) begin
      if (st == 2'd1) return nw ? {2'd1, 2'd1} : {2'd2, 2'd2};
      return {st, 2'd0};
    end
    if (st == 2'd2) return {2'd1, 2'd3};
    if (c == 3'd2) return {2'd1, 2'd0};
    return {st, 2'd0};
  endfunction

  function automatic string tag_of(input logic nw, input logic [1:0] st, input logic [2:0] c);
    if (c == 3'd3) return "R9";
    if (c >= 3'd4) return "R10";
    if (c == 3'd0 && st == 2'd1) return nw ? "R6" : "R4";
    if (c == 3'd0 && st == 2'd2) return "R4";
    if (st == 2'd2) return "R5";
    if (st == 2'd1) return "R2";
    if (c == 3'd2) return "R2";
    return "R10";
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic nw);
    rst = 1'b1;
    gen_sel = nw;
    ins_class = 3'd4;
    @(negedge clk);
    @(negedge clk);
    // R1
    check("R1", {upper_state, dirty_map, pen_code, pen_pulse, blend_dep},
          {2'd0, 16'd0, 2'd0, 1'b0, 1'b0});
    rst = 1'b0;
    m_st = 2'd0;
    m_map = '0;
  endtask

  task automatic step(input logic [2:0] c, input logic [3:0] d, input logic zi);
    logic [3:0]  x;
    logic        exp_dep;
    logic [15:0] exp_map;
    string       t;
    ins_class = c;
    ins_dst = d;
    ins_zero_idiom = zi;
    x = model_xfer(gen_sel, m_st, c);
    t = tag_of(gen_sel, m_st, c);
    exp_dep = gen_sel && c == 3'd0 && m_st == 2'd1 && m_map[d];
    exp_map = m_map;
    if (c == 3'd3) exp_map = '0;
    else if (c == 3'd2) exp_map[d] = 1'b1;
    else if (c == 3'd1) exp_map[d] = 1'b0;
    @(negedge clk);
    // R11: state, code and pulse reflect the previous instruction only
    check(t, {upper_state, pen_code, pen_pulse}, {x[3:2], x[1:0], x[1:0] != 2'd0});
    // R7 / R8
    check(zi ? "R8" : "R7", blend_dep, exp_dep);
    // R3
    check("R3", dirty_map, exp_map);
    m_st = x[3:2];
    m_map = exp_map;
  endtask

  initial begin
    #1_600_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    do_reset(1'b0);
    // Older table: R2 enter dirty, R4 save once, R5 restore, R9 clear
    step(3'd2, 4'd3, 1'b0);
    step(3'd0, 4'd3, 1'b0);
    step(3'd0, 4'd3, 1'b1);
    step(3'd0, 4'd7, 1'b0);
    step(3'd1, 4'd3, 1'b0);
    step(3'd2, 4'd9, 1'b0);
    step(3'd5, 4'd9, 1'b0);
    step(3'd3, 4'd0, 1'b0);
    step(3'd0, 4'd1, 1'b0);
    // Mid-run reset: R1
    step(3'd2, 4'd2, 1'b0);
    do_reset(1'b1);
    // Newer table: R6 self-loop, R7 per-register flag, R8 idiom
    step(3'd2, 4'd5, 1'b0);
    step(3'd0, 4'd5, 1'b1);
    step(3'd0, 4'd5, 1'b0);
    step(3'd0, 4'd6, 1'b1);
    step(3'd1, 4'd5, 1'b0);
    step(3'd0, 4'd5, 1'b0);
    step(3'd7, 4'd5, 1'b0);
    step(3'd3, 4'd5, 1'b0);
    step(3'd0, 4'd5, 1'b1);
    for (int m = 0; m < 2; m++) begin
      do_reset(m[0]);
      for (int i = 0; i < 3000; i++) begin
        logic [2:0] c;
        int r;
        r = $urandom % 16;
        if (r < 6) c = 3'd0;
        else if (r < 9) c = 3'd2;
        else if (r < 12) c = 3'd1;
        else if (r < 13) c = 3'd3;
        else c = 3'($urandom % 8);
        step(c, 4'($urandom % 4), 1'($urandom % 2));
      end
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule